// File: doc/BRIEF.md
# Microcode Sequencer with Encoded Next-Address Control

This block is the control unit of a small multicycle RISC processor built around a single shared bus. A 6-bit micro-program counter addresses a constant control store. Each stored word holds a 17-bit control vector, a 3-bit jump code and a 6-bit absolute target. No word stores its successor address. The successor comes from a small next-address stage that picks one of four sources: the incremented address, the current address (used to wait out a busy memory), the stored target, or the entry point of the instruction group. That entry point is decoded from the opcode through a dispatch table.

The microprogram covers instruction fetch, register ALU operations, immediate ALU operations, load, store, branch-if-zero, branch-if-not-zero, jump, jump-register, jump-and-link, jump-and-link-register, and an ALU operation whose two operands and whose result all live in memory. Every sequence ends by returning to the first fetch word. The datapath is not part of this block. It only consumes `ctl`, and it returns the zero flag of register A and the busy flag of memory.

Top module: `ucode_seq`

## Requirements
- R1: Synchronous active-high `rst` puts the micro-PC at the first fetch word. The cycle after reset shows the MA←PC vector, and a reset in the middle of any sequence aborts it the same way.
- R2: Fetch runs MA←PC, then IR←Memory, then A←PC, then PC←A+4. The IR←Memory word repeats for as long as `busy` is high and advances in the first cycle `busy` is low. `busy` has no effect on any word that is not a wait word.
- R3: The cycle after PC←A+4 enters the group selected by `opcode`. The codes are: 1 register ALU, 2 immediate ALU, 3 load, 4 store, 5 branch-if-zero, 6 branch-if-not-zero, 7 jump, 8 jump-register, 9 jump-and-link, 10 jump-and-link-register, 11 memory-to-memory ALU.
- R4: Register ALU runs A←Reg[rf1], B←Reg[rf2], Reg[rf3]←func(A,B) and then returns to fetch. Immediate ALU is the same except that the second step is B←sext16(Imm).
- R5: Load runs A←Reg[rf1], B←sext16(Imm), MA←A+B, then Reg[rf2]←Memory, which waits on `busy`, then one empty word before fetch. Store is the same except that its memory step is Memory←Reg[rf2].
- R6: Both branches run A←Reg[rf1] and then an empty decision word. Branch-if-zero is taken when `zero`=1 and branch-if-not-zero when `zero`=0. The taken path runs A←PC, B←sext16(Imm), PC←A+B. The untaken path goes straight to fetch.
- R7: Jump runs A←PC, B←sext26(Imm), PC←A+B. Jump-register is the single word PC←Reg[rf1].
- R8: Jump-and-link runs A←PC, Reg[31]←A, B←sext26(Imm), PC←A+B. Jump-and-link-register runs A←PC, Reg[31]←A, PC←Reg[rf1].
- R9: The memory-to-memory op runs MA←Reg[rf1], A←Memory, MA←Reg[rf2], B←Memory, MA←Reg[rf3], Memory←func(A,B), then one empty word. Each memory step waits on `busy`.
- R10: Opcodes 0 and 12 to 63 make the cycle after PC←A+4 return to MA←PC.
- R11: Bit layout of `ctl`:
  - Single-bit fields: bit 0 loads IR, bit 1 loads A, bit 2 loads B, bit 3 loads MA, bit 4 writes a register, bit 5 writes memory.
  - Bus sources: bit 6 register file, bit 7 memory, bit 8 immediate, bit 9 ALU. At most one bus source is set in any word.
  - Bits 12:10 select the register: 0 rf1, 1 rf2, 2 rf3, 3 PC, 4 link register 31, 5 read rf1 and write PC.
  - Bits 14:13 select the immediate: 1 sext16, 2 sext26.
  - Bits 16:15 select the ALU operation: 0 A+B, 1 A+4, 2 pass A, 3 func.
  - A transfer sets only its source and its destination fields. An empty word is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | Register A is zero |
| busy | input | 1 | Memory has not yet completed the access |
| ctl | output | 17 | Control vector for the datapath |

## Verification
The sweep covers all 64 opcode values. Each one is paired with both levels of `zero` and with zero, one or two busy cycles at every wait word. The sweep therefore separates dispatch errors (a wrong entry point, or an unlisted code that fails to fall back to fetch) from jump-code errors (a swapped branch polarity or a wait that ignores `busy`). In the busy-one passes, `busy` is also held high on the ordinary words, so a sequencer that stalls on a non-wait word diverges from the expected trace. A reset applied in the middle of a load wait shows that the abort works.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
   localparam int CTL_W    = 17;
   localparam int UA_W     = 6;
   localparam int OP_W     = 6;
   localparam int PROG_LEN = 48;

   typedef enum logic [2:0] {
      JT_NEXT, JT_SPIN, JT_FETCH, JT_DISP, JT_FEQZ, JT_FNEZ
   } jump_t;

   typedef struct packed {
      logic [1:0] alu_op;
      logic [1:0] imm_sel;
      logic [2:0] reg_sel;
      logic       en_alu;
      logic       en_imm;
      logic       en_mem;
      logic       en_reg;
      logic       mem_wr;
      logic       reg_wr;
      logic       ld_ma;
      logic       ld_b;
      logic       ld_a;
      logic       ld_ir;
   } ctl_t;

   typedef struct packed {
      ctl_t             ctl;
      jump_t            jt;
      logic [UA_W-1:0]  tgt;
   } uword_t;

   localparam logic [2:0] RS_RF1 = 3'd0, RS_RF2 = 3'd1, RS_RF3 = 3'd2,
                          RS_PC  = 3'd3, RS_LNK = 3'd4, RS_R1PC = 3'd5;
   localparam logic [1:0] IM_S16 = 2'd1, IM_S26 = 2'd2;
   localparam logic [1:0] AL_ADD = 2'd0, AL_INC4 = 2'd1, AL_PASS = 2'd2, AL_FN = 2'd3;

   localparam logic [OP_W-1:0] OP_ALU = 6'd1, OP_ALUI = 6'd2, OP_LD = 6'd3,
      OP_ST = 6'd4, OP_BZ = 6'd5, OP_BNZ = 6'd6, OP_J = 6'd7, OP_JR = 6'd8,
      OP_JL = 6'd9, OP_JLR = 6'd10, OP_MM = 6'd11;

   localparam logic [UA_W-1:0] UA_FETCH = 6'd0, UA_ALU = 6'd4, UA_ALUI = 6'd7,
      UA_LD = 6'd10, UA_ST = 6'd15, UA_BZ = 6'd20, UA_BNZ = 6'd25, UA_J = 6'd30,
      UA_JR = 6'd33, UA_JL = 6'd34, UA_JLR = 6'd38, UA_MM = 6'd41;

   typedef enum logic [4:0] {
      ST_IDLE, ST_MA_PC, ST_IR_MEM, ST_A_PC, ST_PC_INC, ST_A_RF1, ST_B_RF2,
      ST_RF3_FN, ST_B_SX16, ST_MA_AB, ST_RF2_MEM, ST_MEM_RF2, ST_PC_AB,
      ST_B_SX26, ST_PC_RF1, ST_LNK_A, ST_MA_RF1, ST_A_MEM, ST_MA_RF2,
      ST_B_MEM, ST_MA_RF3, ST_MEM_FN
   } step_e;

   function automatic ctl_t step_ctl(step_e s);
      ctl_t c;
      c = '0;
      case (s)
         ST_MA_PC:   begin c.en_reg = 1'b1; c.reg_sel = RS_PC;  c.ld_ma = 1'b1; end
         ST_IR_MEM:  begin c.en_mem = 1'b1; c.ld_ir = 1'b1; end
         ST_A_PC:    begin c.en_reg = 1'b1; c.reg_sel = RS_PC;  c.ld_a = 1'b1; end
         ST_PC_INC:  begin c.en_alu = 1'b1; c.alu_op = AL_INC4; c.reg_wr = 1'b1; c.reg_sel = RS_PC; end
         ST_A_RF1:   begin c.en_reg = 1'b1; c.reg_sel = RS_RF1; c.ld_a = 1'b1; end
         ST_B_RF2:   begin c.en_reg = 1'b1; c.reg_sel = RS_RF2; c.ld_b = 1'b1; end
         ST_RF3_FN:  begin c.en_alu = 1'b1; c.alu_op = AL_FN; c.reg_wr = 1'b1; c.reg_sel = RS_RF3; end
         ST_B_SX16:  begin c.en_imm = 1'b1; c.imm_sel = IM_S16; c.ld_b = 1'b1; end
         ST_MA_AB:   begin c.en_alu = 1'b1; c.alu_op = AL_ADD; c.ld_ma = 1'b1; end
         ST_RF2_MEM: begin c.en_mem = 1'b1; c.reg_wr = 1'b1; c.reg_sel = RS_RF2; end
         ST_MEM_RF2: begin c.en_reg = 1'b1; c.reg_sel = RS_RF2; c.mem_wr = 1'b1; end
         ST_PC_AB:   begin c.en_alu = 1'b1; c.alu_op = AL_ADD; c.reg_wr = 1'b1; c.reg_sel = RS_PC; end
         ST_B_SX26:  begin c.en_imm = 1'b1; c.imm_sel = IM_S26; c.ld_b = 1'b1; end
         ST_PC_RF1:  begin c.en_reg = 1'b1; c.reg_sel = RS_R1PC; c.reg_wr = 1'b1; end
         ST_LNK_A:   begin c.en_alu = 1'b1; c.alu_op = AL_PASS; c.reg_wr = 1'b1; c.reg_sel = RS_LNK; end
         ST_MA_RF1:  begin c.en_reg = 1'b1; c.reg_sel = RS_RF1; c.ld_ma = 1'b1; end
         ST_A_MEM:   begin c.en_mem = 1'b1; c.ld_a = 1'b1; end
         ST_MA_RF2:  begin c.en_reg = 1'b1; c.reg_sel = RS_RF2; c.ld_ma = 1'b1; end
         ST_B_MEM:   begin c.en_mem = 1'b1; c.ld_b = 1'b1; end
         ST_MA_RF3:  begin c.en_reg = 1'b1; c.reg_sel = RS_RF3; c.ld_ma = 1'b1; end
         ST_MEM_FN:  begin c.en_alu = 1'b1; c.alu_op = AL_FN; c.mem_wr = 1'b1; end
         default:    c = '0;
      endcase
      return c;
   endfunction

   function automatic uword_t ucode_word(int unsigned a);
      step_e s;
      jump_t j;
      case (a)
         0:  begin s = ST_MA_PC;   j = JT_NEXT;  end
         1:  begin s = ST_IR_MEM;  j = JT_SPIN;  end
         2:  begin s = ST_A_PC;    j = JT_NEXT;  end
         3:  begin s = ST_PC_INC;  j = JT_DISP;  end
         4:  begin s = ST_A_RF1;   j = JT_NEXT;  end
         5:  begin s = ST_B_RF2;   j = JT_NEXT;  end
         6:  begin s = ST_RF3_FN;  j = JT_FETCH; end
         7:  begin s = ST_A_RF1;   j = JT_NEXT;  end
         8:  begin s = ST_B_SX16;  j = JT_NEXT;  end
         9:  begin s = ST_RF3_FN;  j = JT_FETCH; end
         10: begin s = ST_A_RF1;   j = JT_NEXT;  end
         11: begin s = ST_B_SX16;  j = JT_NEXT;  end
         12: begin s = ST_MA_AB;   j = JT_NEXT;  end
         13: begin s = ST_RF2_MEM; j = JT_SPIN;  end
         14: begin s = ST_IDLE;    j = JT_FETCH; end
         15: begin s = ST_A_RF1;   j = JT_NEXT;  end
         16: begin s = ST_B_SX16;  j = JT_NEXT;  end
         17: begin s = ST_MA_AB;   j = JT_NEXT;  end
         18: begin s = ST_MEM_RF2; j = JT_SPIN;  end
         19: begin s = ST_IDLE;    j = JT_FETCH; end
         20: begin s = ST_A_RF1;   j = JT_NEXT;  end
         21: begin s = ST_IDLE;    j = JT_FNEZ;  end
         22: begin s = ST_A_PC;    j = JT_NEXT;  end
         23: begin s = ST_B_SX16;  j = JT_NEXT;  end
         24: begin s = ST_PC_AB;   j = JT_FETCH; end
         25: begin s = ST_A_RF1;   j = JT_NEXT;  end
         26: begin s = ST_IDLE;    j = JT_FEQZ;  end
         27: begin s = ST_A_PC;    j = JT_NEXT;  end
         28: begin s = ST_B_SX16;  j = JT_NEXT;  end
         29: begin s = ST_PC_AB;   j = JT_FETCH; end
         30: begin s = ST_A_PC;    j = JT_NEXT;  end
         31: begin s = ST_B_SX26;  j = JT_NEXT;  end
         32: begin s = ST_PC_AB;   j = JT_FETCH; end
         33: begin s = ST_PC_RF1;  j = JT_FETCH; end
         34: begin s = ST_A_PC;    j = JT_NEXT;  end
         35: begin s = ST_LNK_A;   j = JT_NEXT;  end
         36: begin s = ST_B_SX26;  j = JT_NEXT;  end
         37: begin s = ST_PC_AB;   j = JT_FETCH; end
         38: begin s = ST_A_PC;    j = JT_NEXT;  end
         39: begin s = ST_LNK_A;   j = JT_NEXT;  end
         40: begin s = ST_PC_RF1;  j = JT_FETCH; end
         41: begin s = ST_MA_RF1;  j = JT_NEXT;  end
         42: begin s = ST_A_MEM;   j = JT_SPIN;  end
         43: begin s = ST_MA_RF2;  j = JT_NEXT;  end
         44: begin s = ST_B_MEM;   j = JT_SPIN;  end
         45: begin s = ST_MA_RF3;  j = JT_NEXT;  end
         46: begin s = ST_MEM_FN;  j = JT_SPIN;  end
         47: begin s = ST_IDLE;    j = JT_FETCH; end
         default: begin s = ST_IDLE; j = JT_FETCH; end
      endcase
      return '{ctl: step_ctl(s), jt: j, tgt: UA_FETCH};
   endfunction
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
   import ucseq_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);
   uword_t rom [DEPTH];

   initial begin
      assert (DEPTH >= PROG_LEN && DEPTH <= (1 << UA_W))
         else $error("store depth %0d outside %0d..%0d", DEPTH, PROG_LEN, 1 << UA_W);
   end

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      assign rom[a] = ucode_word(a);
   end

   assign word = rom[addr];

   // R11
   bus_src_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({word.ctl.en_reg, word.ctl.en_mem, word.ctl.en_imm, word.ctl.en_alu}));
endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
   import ucseq_pkg::*;
(
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] entry
);
   always_comb begin
      case (opcode)
         OP_ALU:  entry = UA_ALU;
         OP_ALUI: entry = UA_ALUI;
         OP_LD:   entry = UA_LD;
         OP_ST:   entry = UA_ST;
         OP_BZ:   entry = UA_BZ;
         OP_BNZ:  entry = UA_BNZ;
         OP_J:    entry = UA_J;
         OP_JR:   entry = UA_JR;
         OP_JL:   entry = UA_JL;
         OP_JLR:  entry = UA_JLR;
         OP_MM:   entry = UA_MM;
         default: entry = UA_FETCH;
      endcase
   end
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
   import ucseq_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  jump_t           jt,
   input  logic [UA_W-1:0] tgt,
   input  logic [UA_W-1:0] entry,
   input  logic            zero,
   input  logic            busy,
   output logic [UA_W-1:0] upc
);
   logic [UA_W-1:0] upc_inc;
   logic [UA_W-1:0] upc_nxt;

   assign upc_inc = upc + 1'b1;

   always_comb begin
      case (jt)
         JT_NEXT:  upc_nxt = upc_inc;
         JT_SPIN:  upc_nxt = busy ? upc : upc_inc;
         JT_FETCH: upc_nxt = tgt;
         JT_DISP:  upc_nxt = entry;
         JT_FEQZ:  upc_nxt = zero ? tgt : upc_inc;
         JT_FNEZ:  upc_nxt = zero ? upc_inc : tgt;
         default:  upc_nxt = tgt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) upc <= UA_FETCH;
      else     upc <= upc_nxt;
   end

   // R2
   spin_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (jt == JT_SPIN && busy) |=> (upc == $past(upc)));
   // R3
   disp_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (jt == JT_DISP) |=> (upc == $past(entry)));
   // R6
   cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
      ((jt == JT_FEQZ && zero) || (jt == JT_FNEZ && !zero)) |=> (upc == $past(tgt)));
   // R4
   fetch_ret_chk: assert property (@(posedge clk) disable iff (rst)
      (jt == JT_FETCH) |=> (upc == $past(tgt)));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucseq_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   opcode,
   input  logic              zero,
   input  logic              busy,
   output logic [CTL_W-1:0]  ctl
);
   logic [UA_W-1:0] upc;
   logic [UA_W-1:0] entry;
   uword_t          word;

   ucseq_store #(.DEPTH(DEPTH)) u_store (
      .clk  (clk),
      .rst  (rst),
      .addr (upc),
      .word (word)
   );

   ucseq_dispatch u_disp (
      .opcode (opcode),
      .entry  (entry)
   );

   ucseq_next u_next (
      .clk   (clk),
      .rst   (rst),
      .jt    (word.jt),
      .tgt   (word.tgt),
      .entry (entry),
      .zero  (zero),
      .busy  (busy),
      .upc   (upc)
   );

   assign ctl = word.ctl;

   // R1
   rst_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (upc == UA_FETCH));
endmodule

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  opcode = '0;
   logic        zero = 1'b0;
   logic        busy = 1'b0;
   logic [16:0] ctl;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   string first_tag = "R1 reset";

   always #4 clk = ~clk;

   ucode_seq u_ucode_seq (
      .clk(clk), .rst(rst), .opcode(opcode), .zero(zero), .busy(busy), .ctl(ctl)
   );

   typedef enum int {
      B_IDLE, B_MA_PC, B_IR_MEM, B_A_PC, B_PC_INC, B_A_RF1, B_B_RF2, B_RF3_FN,
      B_B_SX16, B_MA_AB, B_RF2_MEM, B_MEM_RF2, B_PC_AB, B_B_SX26, B_PC_RF1,
      B_LNK_A, B_MA_RF1, B_A_MEM, B_MA_RF2, B_B_MEM, B_MA_RF3, B_MEM_FN
   } bstep_e;

   // Expected vectors built from the R11 bit layout
   function automatic logic [16:0] vec(bstep_e s);
      logic [16:0] v;
      v = '0;
      case (s)
         B_MA_PC:   begin v[6] = 1; v[12:10] = 3; v[3] = 1; end
         B_IR_MEM:  begin v[7] = 1; v[0] = 1; end
         B_A_PC:    begin v[6] = 1; v[12:10] = 3; v[1] = 1; end
         B_PC_INC:  begin v[9] = 1; v[16:15] = 1; v[4] = 1; v[12:10] = 3; end
         B_A_RF1:   begin v[6] = 1; v[12:10] = 0; v[1] = 1; end
         B_B_RF2:   begin v[6] = 1; v[12:10] = 1; v[2] = 1; end
         B_RF3_FN:  begin v[9] = 1; v[16:15] = 3; v[4] = 1; v[12:10] = 2; end
         B_B_SX16:  begin v[8] = 1; v[14:13] = 1; v[2] = 1; end
         B_MA_AB:   begin v[9] = 1; v[16:15] = 0; v[3] = 1; end
         B_RF2_MEM: begin v[7] = 1; v[4] = 1; v[12:10] = 1; end
         B_MEM_RF2: begin v[6] = 1; v[12:10] = 1; v[5] = 1; end
         B_PC_AB:   begin v[9] = 1; v[16:15] = 0; v[4] = 1; v[12:10] = 3; end
         B_B_SX26:  begin v[8] = 1; v[14:13] = 2; v[2] = 1; end
         B_PC_RF1:  begin v[6] = 1; v[12:10] = 5; v[4] = 1; end
         B_LNK_A:   begin v[9] = 1; v[16:15] = 2; v[4] = 1; v[12:10] = 4; end
         B_MA_RF1:  begin v[6] = 1; v[12:10] = 0; v[3] = 1; end
         B_A_MEM:   begin v[7] = 1; v[1] = 1; end
         B_MA_RF2:  begin v[6] = 1; v[12:10] = 1; v[3] = 1; end
         B_B_MEM:   begin v[7] = 1; v[2] = 1; end
         B_MA_RF3:  begin v[6] = 1; v[12:10] = 2; v[3] = 1; end
         B_MEM_FN:  begin v[9] = 1; v[16:15] = 3; v[5] = 1; end
         default:   v = '0;
      endcase
      return v;
   endfunction

   // Called at a falling edge: check the current word, drive busy, move on one cycle
   task automatic step(bstep_e s, bit busy_v, string tag);
      logic [16:0] e;
      e = vec(s);
      vectors++;
      if (ctl !== e) begin
         fails++;
         $display("FAIL %s: ctl=%h expected %h (opcode=%0d zero=%0b)", tag, ctl, e, opcode, zero);
      end
      busy = busy_v;
      @(negedge clk);
   endtask

   task automatic wait_step(bstep_e s, int waits, string tag);
      for (int k = 0; k < waits; k++) step(s, 1'b1, tag);
      step(s, 1'b0, tag);
   endtask

   task automatic run_instr(logic [5:0] op, bit z, int waits);
      bit nz;
      nz = waits[0];
      opcode = op;
      zero = z;
      step(B_MA_PC, nz, first_tag);
      first_tag = "R2 fetch";
      wait_step(B_IR_MEM, waits, "R2 fetch wait");
      step(B_A_PC, nz, "R2 fetch");
      step(B_PC_INC, nz, "R3 dispatch");
      case (op)
         6'd1: begin
            step(B_A_RF1, nz, "R4 reg alu"); step(B_B_RF2, nz, "R4 reg alu");
            step(B_RF3_FN, nz, "R4 reg alu");
         end
         6'd2: begin
            step(B_A_RF1, nz, "R4 imm alu"); step(B_B_SX16, nz, "R4 imm alu");
            step(B_RF3_FN, nz, "R4 imm alu");
         end
         6'd3: begin
            step(B_A_RF1, nz, "R5 load"); step(B_B_SX16, nz, "R5 load");
            step(B_MA_AB, nz, "R5 load"); wait_step(B_RF2_MEM, waits, "R5 load wait");
            step(B_IDLE, nz, "R5 load");
         end
         6'd4: begin
            step(B_A_RF1, nz, "R5 store"); step(B_B_SX16, nz, "R5 store");
            step(B_MA_AB, nz, "R5 store"); wait_step(B_MEM_RF2, waits, "R5 store wait");
            step(B_IDLE, nz, "R5 store");
         end
         6'd5, 6'd6: begin
            step(B_A_RF1, nz, "R6 branch");
            step(B_IDLE, nz, "R6 branch decide");
            if ((op == 6'd5) == z) begin
               step(B_A_PC, nz, "R6 taken"); step(B_B_SX16, nz, "R6 taken");
               step(B_PC_AB, nz, "R6 taken");
            end
            first_tag = "R6 untaken or done";
         end
         6'd7: begin
            step(B_A_PC, nz, "R7 jump"); step(B_B_SX26, nz, "R7 jump");
            step(B_PC_AB, nz, "R7 jump");
         end
         6'd8: step(B_PC_RF1, nz, "R7 jump reg");
         6'd9: begin
            step(B_A_PC, nz, "R8 jal"); step(B_LNK_A, nz, "R8 jal");
            step(B_B_SX26, nz, "R8 jal"); step(B_PC_AB, nz, "R8 jal");
         end
         6'd10: begin
            step(B_A_PC, nz, "R8 jalr"); step(B_LNK_A, nz, "R8 jalr");
            step(B_PC_RF1, nz, "R8 jalr");
         end
         6'd11: begin
            step(B_MA_RF1, nz, "R9 memop"); wait_step(B_A_MEM, waits, "R9 memop wait");
            step(B_MA_RF2, nz, "R9 memop"); wait_step(B_B_MEM, waits, "R9 memop wait");
            step(B_MA_RF3, nz, "R9 memop"); wait_step(B_MEM_FN, waits, "R9 memop wait");
            step(B_IDLE, nz, "R9 memop");
         end
         default: first_tag = "R10 unlisted opcode";
      endcase
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int op = 0; op < 64; op++)
         for (int z = 0; z < 2; z++)
            for (int w = 0; w < 3; w++)
               run_instr(op[5:0], z[0], w);
      // R1: reset in the middle of a load wait
      opcode = 6'd3;
      step(B_MA_PC, 1'b0, "R2 fetch");
      step(B_IR_MEM, 1'b0, "R2 fetch");
      step(B_A_PC, 1'b0, "R2 fetch");
      step(B_PC_INC, 1'b0, "R3 dispatch");
      step(B_A_RF1, 1'b0, "R5 load");
      step(B_B_SX16, 1'b0, "R5 load");
      step(B_MA_AB, 1'b0, "R5 load");
      rst = 1'b1;
      step(B_RF2_MEM, 1'b1, "R5 load wait");
      rst = 1'b0;
      first_tag = "R1 reset abort";
      run_instr(6'd1, 1'b0, 0);
      step(B_MA_PC, 1'b0, "R4 return to fetch");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule